// File: doc/BRIEF.md
# SPI Master with Burst Chip-Select Framing

This block is a single-target SPI master in mode 0. Software-side logic writes words into an 8-entry transmit queue. The block shifts each word out MSB first as a burst of a programmable number of bits. Bits clocked in from the target are collected into an 8-entry receive queue, one word per burst. The SCLK rate is set by a half-period count in system clocks.

The chip-select line can behave in one of two ways. In hold framing, consecutive queued words go out back to back inside one chip-select frame, and the frame ends only when the transmit queue runs dry. In pulse framing, chip select drops after every burst and stays inactive for a programmed number of SCLK periods before the next burst. Transfers normally wait for an exchange command. An auto-start mode instead begins as soon as a word is queued; in that mode the framing select is ignored and hold framing applies. After every frame, whatever the mode, the same programmed idle time is inserted.

Top module: `spi_burst_master`

## Requirements
- R1: While reset is held and right after it is released, cs_no is 1, sclk_o is 0, busy_o is 0, xch_o is 0, rx_empty_o is 1 and tx_full_o is 0.
- R2: SCLK is low whenever chip select is inactive. Each SCLK high phase and low phase lasts cfg_half_i clock cycles (cfg_half_i of 1 or more). MOSI changes only while SCLK is low, and the first rising edge comes cfg_half_i cycles after chip select goes active.
- R3: A burst carries cfg_len_i+1 bits, from 1 to 32, taken from the low end of the queued word and sent most significant bit first.
- R4: MISO is sampled on each SCLK rising edge. At the end of each burst the received bits, right-aligned with the upper bits zero, are pushed into the receive queue. A burst that ends while that queue holds 8 words is dropped and does not change the stored words.
- R5: With cfg_auto_start_i at 0, queued words are not sent until xch_set_i is pulsed; until then cs_no stays 1.
- R6: In hold framing (cfg_cs_pulse_i at 0), a burst that ends with words still queued is followed at once by the next burst in the same chip-select frame. cs_no rises cfg_half_i cycles after the last SCLK falling edge of the frame.
- R7: In pulse framing (cfg_cs_pulse_i at 1, cfg_auto_start_i at 0), every burst forms its own frame. cs_no stays high for exactly 2*cfg_wait_i*cfg_half_i+1 cycles before the next frame.
- R8: With cfg_auto_start_i at 1, a transfer begins without xch_set_i once the transmit queue is non-empty, and cfg_cs_pulse_i has no effect: words queued in time share one frame.
- R9: xch_o is set by xch_set_i and clears at the end of a burst that finds the transmit queue empty. busy_o equals the inverse of cs_no.
- R10: The transmit queue holds 8 words. tx_full_o is 1 when it holds 8, and a write made while full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_half_i | input | 8 | SCLK half period in clock cycles, 1 or more |
| cfg_len_i | input | 5 | Burst length minus one |
| cfg_cs_pulse_i | input | 1 | 1: chip select drops after every burst |
| cfg_auto_start_i | input | 1 | 1: start on queue write, framing select ignored |
| cfg_wait_i | input | 8 | Idle SCLK periods after each frame |
| xch_set_i | input | 1 | Exchange command pulse |
| xch_o | output | 1 | Exchange command pending |
| tx_wr_i | input | 1 | Transmit queue write strobe |
| tx_data_i | input | 32 | Transmit word |
| tx_full_o | output | 1 | Transmit queue full |
| rx_rd_i | input | 1 | Receive queue read strobe |
| rx_data_o | output | 32 | Receive queue head word |
| rx_empty_o | output | 1 | Receive queue empty |
| busy_o | output | 1 | Chip select active |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
The properties assume the configuration inputs hold steady from the start of a frame until its idle gap has ended. They also assume cfg_half_i is never zero and the receive queue is read only when it is not empty. The stimulus changes configuration only while the line has been idle longer than the gap, and it always programs a half period of one or more. It reads the receive queue only for words it knows arrived. MISO is tied to the inverse of MOSI, so received words can be predicted from the transmitted ones.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL,
    ST_GAP
  } eng_state_e;
endpackage

// File: rtl/spi_bm_fifo.sv
module spi_bm_fifo #(
  parameter  int W     = 32,
  parameter  int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt != '0);
  assign data_o  = mem[rd_ptr];
  assign count_o = cnt;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter #(
  parameter  int DATA_W = 32,
  localparam int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_word_o
);
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic [LEN_W-1:0]  pad;

  // unused top bits: left-align burst MSB, mask on receive
  assign pad       = LEN_W'(DATA_W - 1) - len_i;
  assign mosi_o    = tx_sh[DATA_W-1];
  assign rx_word_o = rx_sh & ({DATA_W{1'b1}} >> pad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load_i)       tx_sh <= load_data_i << pad;
      else if (shift_i) tx_sh <= tx_sh << 1;
      if (sample_i)     rx_sh <= {rx_sh[DATA_W-2:0], miso_i};
    end
  end
endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine
  import spi_bm_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int DIV_W  = 8,
  parameter  int WAIT_W = 8,
  localparam int LEN_W  = $clog2(DATA_W),
  localparam int GAP_W  = WAIT_W + DIV_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  cfg_half_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              cfg_cs_pulse_i,
  input  logic              cfg_auto_start_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              xch_set_i,
  input  logic              tx_empty_i,
  output logic              load_o,
  output logic              shift_o,
  output logic              sample_o,
  output logic              burst_end_o,
  output logic              xch_o,
  output logic              sclk_o,
  output logic              cs_no
);
  eng_state_e       state;
  logic [DIV_W-1:0] ph_cnt;
  logic [GAP_W-1:0] gap_cnt, gap_len;
  logic [LEN_W-1:0] bit_cnt;
  logic             sclk_q, cs_nq, xch_q;
  logic             pulse_eff, go, ph_end, last_bit, burst_end, cont;

  assign pulse_eff = cfg_cs_pulse_i & ~cfg_auto_start_i;
  assign go        = !tx_empty_i && (cfg_auto_start_i || xch_q);
  assign ph_end    = (ph_cnt == cfg_half_i - DIV_W'(1));
  assign last_bit  = (bit_cnt == '0);
  assign burst_end = (state == ST_HIGH) && ph_end && last_bit;
  assign cont      = burst_end && !pulse_eff && !tx_empty_i;
  assign gap_len   = (GAP_W'(cfg_wait_i) * GAP_W'(cfg_half_i)) << 1;

  assign load_o      = ((state == ST_IDLE) && go) || cont;
  assign shift_o     = (state == ST_HIGH) && ph_end && !last_bit;
  assign sample_o    = (state == ST_LOW) && ph_end;
  assign burst_end_o = burst_end;
  assign xch_o       = xch_q;
  assign sclk_o      = sclk_q;
  assign cs_no       = cs_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      ph_cnt  <= '0;
      gap_cnt <= '0;
      bit_cnt <= '0;
      sclk_q  <= 1'b0;
      cs_nq   <= 1'b1;
      xch_q   <= 1'b0;
    end else begin
      if (xch_set_i)                    xch_q <= 1'b1;
      else if (burst_end && tx_empty_i) xch_q <= 1'b0;

      unique case (state)
        ST_IDLE: if (go) begin
          state   <= ST_LOW;
          cs_nq   <= 1'b0;
          ph_cnt  <= '0;
          bit_cnt <= cfg_len_i;
        end
        ST_LOW: if (ph_end) begin
          ph_cnt <= '0;
          sclk_q <= 1'b1;
          state  <= ST_HIGH;
        end else ph_cnt <= ph_cnt + DIV_W'(1);
        ST_HIGH: if (ph_end) begin
          ph_cnt <= '0;
          sclk_q <= 1'b0;
          if (!last_bit) begin
            bit_cnt <= bit_cnt - LEN_W'(1);
            state   <= ST_LOW;
          end else if (cont) begin
            bit_cnt <= cfg_len_i;
            state   <= ST_LOW;
          end else state <= ST_TRAIL;
        end else ph_cnt <= ph_cnt + DIV_W'(1);
        ST_TRAIL: if (ph_end) begin
          ph_cnt  <= '0;
          cs_nq   <= 1'b1;
          gap_cnt <= '0;
          state   <= (gap_len == '0) ? ST_IDLE : ST_GAP;
        end else ph_cnt <= ph_cnt + DIV_W'(1);
        ST_GAP: if (gap_cnt == gap_len - GAP_W'(1)) state <= ST_IDLE;
                else gap_cnt <= gap_cnt + GAP_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 8,
  parameter  int DIV_W  = 8,
  parameter  int WAIT_W = 8,
  localparam int LEN_W  = $clog2(DATA_W),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  cfg_half_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              cfg_cs_pulse_i,
  input  logic              cfg_auto_start_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              xch_set_i,
  output logic              xch_o,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_full_o,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_empty_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [DATA_W-1:0] tx_head, rx_word;
  logic              tx_empty, rx_full, tx_pop, rx_push, shift_en, sample_en;

  assign tx_empty   = (tx_cnt == '0);
  assign tx_full_o  = (tx_cnt == CNT_W'(DEPTH));
  assign rx_full    = (rx_cnt == CNT_W'(DEPTH));
  assign rx_empty_o = (rx_cnt == '0);
  assign busy_o     = ~cs_no;

  spi_bm_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_wr_i), .data_i(tx_data_i), .pop_i(tx_pop),
    .data_o(tx_head), .count_o(tx_cnt)
  );

  spi_bm_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .data_i(rx_word), .pop_i(rx_rd_i),
    .data_o(rx_data_o), .count_o(rx_cnt)
  );

  spi_bm_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .WAIT_W(WAIT_W)) u_engine (
    .clk_i, .rst_ni,
    .cfg_half_i, .cfg_len_i, .cfg_cs_pulse_i, .cfg_auto_start_i, .cfg_wait_i,
    .xch_set_i, .tx_empty_i(tx_empty),
    .load_o(tx_pop), .shift_o(shift_en), .sample_o(sample_en),
    .burst_end_o(rx_push), .xch_o, .sclk_o, .cs_no
  );

  spi_bm_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i, .rst_ni,
    .len_i(cfg_len_i), .load_i(tx_pop), .load_data_i(tx_head),
    .shift_i(shift_en), .sample_i(sample_en), .miso_i,
    .mosi_o, .rx_word_o(rx_word)
  );
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sclk_i,
  input logic          cs_ni,
  input logic          mosi_i,
  input logic          xch_i,
  input logic          auto_i,
  input logic          tx_empty_i,
  input logic          tx_full_i,
  input logic          tx_wr_i,
  input logic          tx_pop_i,
  input logic [CW-1:0] tx_cnt_i,
  input logic          rx_full_i,
  input logic          rx_push_i,
  input logic          rx_rd_i,
  input logic [CW-1:0] rx_cnt_i
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !sclk_i); // R2
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && $past(sclk_i)) |-> $stable(mosi_i)); // R2
  AST_RX_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_i && rx_push_i && !rx_rd_i) |=> (rx_cnt_i == $past(rx_cnt_i))); // R4
  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_ni) |-> ($past(xch_i) || $past(auto_i))); // R5
  AST_XCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xch_i && !tx_empty_i) |=> xch_i); // R9
  AST_TX_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_i && tx_wr_i && !tx_pop_i) |=> (tx_cnt_i == $past(tx_cnt_i))); // R10
endmodule

bind spi_burst_master spi_burst_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .sclk_i(sclk_o), .cs_ni(cs_no), .mosi_i(mosi_o), .xch_i(xch_o),
  .auto_i(cfg_auto_start_i), .tx_empty_i(tx_empty), .tx_full_i(tx_full_o),
  .tx_wr_i(tx_wr_i), .tx_pop_i(tx_pop), .tx_cnt_i(tx_cnt),
  .rx_full_i(rx_full), .rx_push_i(rx_push), .rx_rd_i(rx_rd_i), .rx_cnt_i(rx_cnt)
);

// File: tb/spi_burst_master_bench.sv
`timescale 1ns/1ps
module spi_burst_master_bench;
  typedef struct packed {
    logic       pulse;
    logic       auto_s;
    logic [4:0] len;
    logic [7:0] half;
    logic [7:0] wait_n;
    logic [3:0] nw;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 5'd7,  8'd2, 8'd0, 4'd4},
    '{1'b1, 1'b0, 5'd7,  8'd1, 8'd5, 4'd3},
    '{1'b1, 1'b0, 5'd31, 8'd3, 8'd2, 4'd2},
    '{1'b0, 1'b1, 5'd15, 8'd2, 8'd0, 4'd3},
    '{1'b1, 1'b1, 5'd0,  8'd1, 8'd3, 4'd5},
    '{1'b1, 1'b0, 5'd0,  8'd2, 8'd0, 4'd3},
    '{1'b0, 1'b0, 5'd12, 8'd4, 8'd1, 4'd2}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  cfg_half = 8'd1, cfg_wait = 8'd0;
  logic [4:0]  cfg_len = 5'd7;
  logic        cfg_pulse = 1'b0, cfg_auto = 1'b0;
  logic        xch_set = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
  logic [31:0] tx_data = '0;
  logic        xch, tx_full, rx_empty, busy, sclk, mosi, cs_n;
  logic [31:0] rx_data;
  logic        miso;

  always #2.5 clk = ~clk;
  assign miso = ~mosi;

  spi_burst_master u_spi_burst_master (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_half_i(cfg_half), .cfg_len_i(cfg_len), .cfg_cs_pulse_i(cfg_pulse),
    .cfg_auto_start_i(cfg_auto), .cfg_wait_i(cfg_wait),
    .xch_set_i(xch_set), .xch_o(xch),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_full_o(tx_full),
    .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_empty_o(rx_empty),
    .busy_o(busy), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic mon_clr = 1'b0;
  int exp_gap = 1;

  // line monitor
  logic [31:0] cap_words [16];
  logic [31:0] cap;
  int ncap, bits, frames, sclk_err, mosi_err, trail_err, gap_err, busy_err;
  int hi_cnt, hi_run, cyc, last_fall;
  logic ps = 1'b0, pc = 1'b1, pm = 1'b0;

  function automatic logic [31:0] msk(input logic [4:0] l);
    return 32'hFFFF_FFFF >> (5'd31 - l);
  endfunction

  function automatic logic [31:0] mk_word(input int v, input int k);
    return (32'h5A3C_96E1 ^ (32'(v) * 32'h0101_0101)) + 32'(k) * 32'h9E37_79B9;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      ncap = 0; bits = 0; cap = '0; frames = 0; sclk_err = 0; mosi_err = 0;
      trail_err = 0; gap_err = 0; busy_err = 0; hi_cnt = 0; hi_run = 0;
    end else if (rst_n) begin
      if (busy !== !cs_n) busy_err++;
      if (sclk && ps && mosi !== pm) mosi_err++;
      if (sclk && !ps) begin
        cap = {cap[30:0], mosi};
        bits++;
        if (bits == int'(cfg_len) + 1) begin
          if (ncap < 16) cap_words[ncap] = cap & msk(cfg_len);
          ncap++;
          bits = 0;
        end
      end
      if (!sclk && ps) begin
        if (hi_cnt != int'(cfg_half)) sclk_err++;
        last_fall = cyc;
      end
      hi_cnt = sclk ? hi_cnt + 1 : 0;
      if (!cs_n && pc) begin
        if (frames > 0 && hi_run != exp_gap) gap_err++;
        frames++;
        bits = 0;
      end
      if (cs_n && !pc && (cyc - last_fall) != int'(cfg_half)) trail_err++;
      if (cs_n) hi_run = pc ? hi_run + 1 : 1;
    end
    ps = sclk; pc = cs_n; pm = mosi;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic pulse_xch();
    @(negedge clk); xch_set = 1'b1;
    @(negedge clk); xch_set = 1'b0;
  endtask

  task automatic read_rx(input logic [31:0] exp, input string tag);
    @(negedge clk);
    chk(rx_data === exp, tag, rx_data, exp);
    rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_done(input int n);
    while (ncap < n || !cs_n) @(negedge clk);
    repeat (exp_gap + 4) @(negedge clk);
  endtask

  task automatic run_vec(input int v);
    vec_t c;
    bit pe;
    int n;
    c = VECS[v];
    n = int'(c.nw);
    pe = c.pulse && !c.auto_s;
    cfg_half = c.half; cfg_len = c.len; cfg_wait = c.wait_n;
    cfg_pulse = c.pulse; cfg_auto = c.auto_s;
    exp_gap = 2 * int'(c.wait_n) * int'(c.half) + 1;
    clear_mon();
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tx_wr = 1'b1; tx_data = mk_word(v, k);
    end
    @(negedge clk); tx_wr = 1'b0;
    if (!c.auto_s) begin
      repeat (20) @(negedge clk);
      chk(cs_n === 1'b1, "R5 queued words wait for exchange", 32'(cs_n), 1);
      pulse_xch();
      chk(xch === 1'b1, "R9 exchange flag set", 32'(xch), 1);
    end
    wait_done(n);
    for (int k = 0; k < n; k++)
      chk(cap_words[k] === (mk_word(v, k) & msk(c.len)), "R3 mosi word",
          cap_words[k], mk_word(v, k) & msk(c.len));
    if (pe) chk(frames == n, "R7 one frame per burst", frames, n);
    else if (c.auto_s) chk(frames == 1, "R8 single frame auto start", frames, 1);
    else chk(frames == 1, "R6 single held frame", frames, 1);
    chk(sclk_err == 0, "R2 sclk high phase length", sclk_err, 0);
    chk(mosi_err == 0, "R2 mosi stable while sclk high", mosi_err, 0);
    chk(trail_err == 0, "R6 trailing half period", trail_err, 0);
    if (pe) chk(gap_err == 0, "R7 inter-burst gap", gap_err, 0);
    chk(busy_err == 0, "R9 busy follows chip select", busy_err, 0);
    chk(xch === 1'b0, "R9 exchange flag cleared", 32'(xch), 0);
    for (int k = 0; k < n; k++)
      read_rx(~mk_word(v, k) & msk(c.len), "R4 received word");
    @(negedge clk);
    chk(rx_empty === 1'b1, "R4 receive queue drained", 32'(rx_empty), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1 && sclk === 0 && busy === 0 && xch === 0 && rx_empty === 1 &&
        tx_full === 0, "R1 outputs in reset", {cs_n, sclk, busy, xch, rx_empty, tx_full},
        6'b100010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1 && sclk === 0 && busy === 0 && xch === 0 && rx_empty === 1 &&
        tx_full === 0, "R1 outputs after reset", {cs_n, sclk, busy, xch, rx_empty, tx_full},
        6'b100010);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R10: ninth write while full is discarded
    cfg_half = 8'd1; cfg_len = 5'd7; cfg_wait = 8'd0; cfg_pulse = 1'b0; cfg_auto = 1'b0;
    exp_gap = 1;
    clear_mon();
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      if (k == 8) chk(tx_full === 1'b1, "R10 full at eight words", 32'(tx_full), 1);
      tx_wr = 1'b1; tx_data = mk_word(10, k);
    end
    @(negedge clk); tx_wr = 1'b0;
    pulse_xch();
    wait_done(8);
    repeat (10) @(negedge clk);
    chk(ncap == 8, "R10 write while full discarded", ncap, 8);
    chk(frames == 1, "R6 eight words in one frame", frames, 1);
    for (int k = 0; k < 8; k++)
      chk(cap_words[k] === (mk_word(10, k) & 32'hFF), "R10 queued word order",
          cap_words[k], mk_word(10, k) & 32'hFF);

    // R4: burst into a full receive queue is dropped
    clear_mon();
    @(negedge clk); tx_wr = 1'b1; tx_data = mk_word(11, 0);
    @(negedge clk); tx_wr = 1'b0;
    pulse_xch();
    wait_done(1);
    for (int k = 0; k < 8; k++)
      read_rx(~mk_word(10, k) & 32'hFF, "R4 stored words kept when full");
    @(negedge clk);
    chk(rx_empty === 1'b1, "R4 overflow burst dropped", 32'(rx_empty), 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    done = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
      $finish;
    end
  end
endmodule